// File: doc/BRIEF.md
# Byte-Aligned Double-Buffered Serial Output Shifter

This block turns bytes written over a parallel port into a serial test-data stream. Two byte-wide holding slots sit between the write port and the serial pin. While one slot is being shifted out, the other can be filled. A status output tells the writer whether a slot is free.

The block keeps no bit position of its own. A 3-bit alignment count is shared by every shifter in the scan controller, and this count chooses which bit of the oldest held byte drives the serial output on each enabled shift tick. A slot is released on the tick where the count is 7. As a result, a shifter that is switched on partway through a byte sends only the remaining bits of that byte. Realigning is left to the controller. The enable must stay steady while shifting is in progress.

Top module: `scan_tdo_shifter`

## Requirements
- R1: After a synchronous reset, `not_full` is 1, `sdo` is 0 and no byte is held.
- R2: `not_full` is 1 exactly when fewer than two bytes are held. Two writes with no release lower it.
- R3: A write while `not_full` is 0 is dropped. The held bytes and their order are unchanged.
- R4: Held bytes leave in the order they were accepted, with the slots used alternately.
- R5: On a clock edge with `shift_en` high and a byte held, `sdo` takes bit number `align_cnt` of the oldest held byte (bit 0 = LSB). The new value is visible after that edge, so a byte started at count 0 leaves LSB first.
- R6: The oldest byte is released on an enabled tick with `align_cnt` = 7, which frees its slot for the next write. A write refused on that same edge stays refused.
- R7: If shifting is enabled while a byte is held and `align_cnt` = k, only bits k to 7 of that byte are sent (five bits when k = 3). The next byte then starts at count 0.
- R8: An enabled tick with no byte held leaves `sdo` unchanged.
- R9: While `shift_en` is low, `sdo` is unchanged and no byte is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to queue |
| not_full | output | 1 | High when at least one slot is free |
| shift_en | input | 1 | Shift tick for this shifter (function enabled and test clock active) |
| align_cnt | input | 3 | Shared alignment count, bit index for this tick |
| sdo | output | 1 | Serial test data out |

## Verification
The main stream sends 256 distinct byte values back to back, with writes made whenever a slot is free. This pattern tells LSB-first order apart from MSB-first order, and catches a swapped slot order. A shifter enabled when the shared count is 3 separates a shifter that counts its own bits from one that follows the shared count: only the latter sends five bits and then starts the next byte at count 0. Writes made while both slots are full show whether a dropped byte corrupts a held one. Ticks with no byte held, and ticks with the enable low, show whether the output holds and whether the release is gated correctly.

// File: rtl/scan_shift_pkg.sv
`timescale 1ns/1ps
package scan_shift_pkg;
    parameter int BYTE_W  = 8;
    parameter int CNT_W   = 3;
    parameter int NUM_BUF = 2;

    localparam int PTR_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
    localparam int OCC_W = $clog2(NUM_BUF + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef struct packed {
        logic  full;
        byte_t data;
    } slot_t;

    localparam cnt_t LAST_BIT = cnt_t'(BYTE_W - 1);

    function automatic ptr_t ptr_next(input ptr_t p);
        return (p == ptr_t'(NUM_BUF - 1)) ? '0 : p + ptr_t'(1);
    endfunction

    function automatic logic bit_at(input byte_t b, input cnt_t idx);
        return b[idx];
    endfunction
endpackage

// File: rtl/scan_buf_bank.sv
`timescale 1ns/1ps
module scan_buf_bank
    import scan_shift_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t wr_data,
    input  logic  release_i,
    output slot_t head,
    output logic  not_full
);
    slot_t slots_q [NUM_BUF];
    ptr_t  wr_ptr_q;
    ptr_t  rd_ptr_q;
    logic  wr_accept;
    logic  [NUM_BUF-1:0] full_vec;

    always_comb begin
        for (int i = 0; i < NUM_BUF; i++) begin
            full_vec[i] = slots_q[i].full;
        end
    end

    assign not_full  = ~&full_vec;
    assign wr_accept = wr_en && !slots_q[wr_ptr_q].full;
    assign head      = slots_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            for (int i = 0; i < NUM_BUF; i++) begin
                slots_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_BUF; i++) begin
                if (release_i && rd_ptr_q == ptr_t'(i)) begin
                    slots_q[i].full <= 1'b0;
                end
                if (wr_accept && wr_ptr_q == ptr_t'(i)) begin
                    slots_q[i].full <= 1'b1;
                    slots_q[i].data <= wr_data;
                end
            end
            if (wr_accept) begin
                wr_ptr_q <= ptr_next(wr_ptr_q);
            end
            if (release_i) begin
                rd_ptr_q <= ptr_next(rd_ptr_q);
            end
        end
    end
endmodule

// File: rtl/scan_out_stage.sv
`timescale 1ns/1ps
module scan_out_stage
    import scan_shift_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_en,
    input  cnt_t  align_cnt,
    input  slot_t head,
    output logic  release_o,
    output logic  sdo
);
    logic do_shift;

    assign do_shift  = shift_en && head.full;
    assign release_o = do_shift && (align_cnt == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo <= 1'b0;
        end else if (do_shift) begin
            sdo <= bit_at(head.data, align_cnt);
        end
    end
endmodule

// File: rtl/scan_tdo_shifter.sv
`timescale 1ns/1ps
module scan_tdo_shifter
    import scan_shift_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       not_full,
    input  logic       shift_en,
    input  logic [2:0] align_cnt,
    output logic       sdo
);
    slot_t head;
    logic  release_w;

    scan_buf_bank i_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (byte_t'(wr_data)),
        .release_i (release_w),
        .head      (head),
        .not_full  (not_full)
    );

    scan_out_stage i_out (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .align_cnt (cnt_t'(align_cnt)),
        .head      (head),
        .release_o (release_w),
        .sdo       (sdo)
    );
endmodule

// File: rtl/scan_tdo_shifter_chk.sv
`timescale 1ns/1ps
module scan_tdo_shifter_chk
    import scan_shift_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       not_full,
    input logic       shift_en,
    input logic [2:0] align_cnt,
    input logic       sdo
);
    logic [OCC_W-1:0] occ_q;
    logic inc, dec, at_wrap;

    assign at_wrap = shift_en && (align_cnt == 3'd7);
    assign inc     = wr_en && not_full;
    assign dec     = at_wrap && (occ_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + OCC_W'(inc) - OCC_W'(dec);
        end
    end

    AST_FLAG_TRACKS_FILL: assert property (@(posedge clk) disable iff (rst)
        not_full == (occ_q != OCC_W'(NUM_BUF))); // R2
    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (!not_full && wr_en && !at_wrap) |=> !not_full); // R3
    AST_RELEASE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!not_full && at_wrap) |=> not_full); // R6
    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (shift_en && occ_q == '0) |=> $stable(sdo)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sdo)); // R9
endmodule

bind scan_tdo_shifter scan_tdo_shifter_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .not_full  (not_full),
    .shift_en  (shift_en),
    .align_cnt (align_cnt),
    .sdo       (sdo)
);

// File: tb/test_scan_tdo_shifter.sv
`timescale 1ns/1ps
module test_scan_tdo_shifter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       not_full;
    logic       shift_en = 1'b0;
    logic [2:0] align_cnt = '0;
    logic       sdo;

    int vectors = 0;
    int errors  = 0;
    logic [2:0] cnt = '0;
    logic [7:0] mq [2];
    int   mcnt = 0;
    logic exp_sdo = 1'b0;
    string req = "R1";

    always #2.5 clk = ~clk;

    scan_tdo_shifter i_scan_tdo_shifter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .not_full(not_full), .shift_en(shift_en),
        .align_cnt(align_cnt), .sdo(sdo)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic en, input logic we, input logic [7:0] d);
        int old;
        @(negedge clk);
        shift_en = en; wr_en = we; wr_data = d; align_cnt = cnt;
        old = mcnt;
        if (en && mcnt > 0) begin
            exp_sdo = mq[0][cnt];
            if (cnt == 3'd7) begin
                mq[0] = mq[1];
                mcnt--;
            end
        end
        if (we && old < 2) begin
            mq[mcnt] = d;
            mcnt++;
        end
        cnt = cnt + 3'd1;
        @(posedge clk); #1;
        check({req, " sdo"}, sdo, exp_sdo);
        check("R2 not_full", not_full, mcnt < 2);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; shift_en = 0; wr_en = 0;
        @(negedge clk);
        cnt = cnt + 3'd1;
        rst = 1'b0;
        mcnt = 0; exp_sdo = 1'b0;
        #1;
        check("R1 reset not_full", not_full, 1'b1);
        check("R1 reset sdo", sdo, 1'b0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int sent;
        repeat (3) @(negedge clk);
        do_reset();

        // R4 / R5 / R6: stream of 256 distinct bytes, LSB first, from count 0
        req = "R5";
        while (cnt != 3'd0) step(1'b0, 1'b0, 8'h00);
        sent = 0;
        while (sent < 256 || mcnt > 0) begin
            logic w;
            w = (sent < 256) && (mcnt < 2);
            step(1'b1, w, 8'(sent * 37 + 11));
            if (w) sent++;
        end
        req = "R4";
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 8'h00);

        // R3: overfill with shifting idle, then drain
        do_reset();
        req = "R3";
        step(1'b0, 1'b1, 8'hA5);
        step(1'b0, 1'b1, 8'h3C);
        step(1'b0, 1'b1, 8'hFF);
        step(1'b0, 1'b1, 8'h00);
        // R9: no shifting while disabled, contents kept
        req = "R9";
        for (int k = 0; k < 10; k++) step(1'b0, 1'b0, 8'h00);
        req = "R3";
        while (cnt != 3'd0) step(1'b0, 1'b0, 8'h00);
        for (int k = 0; k < 20; k++) step(1'b1, 1'b0, 8'h00);

        // R6: full write refused on the releasing edge
        do_reset();
        req = "R6";
        while (cnt != 3'd0) step(1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b1, 8'h81);
        step(1'b1, 1'b1, 8'h7E);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 8'h00);
        step(1'b1, 1'b1, 8'h55);
        for (int k = 0; k < 24; k++) step(1'b1, 1'b0, 8'h00);

        // R7: enable with count at 3 sends five bits of the first byte
        do_reset();
        req = "R7";
        step(1'b0, 1'b1, 8'b1110_0111);
        step(1'b0, 1'b1, 8'b0101_1010);
        while (cnt != 3'd3) step(1'b0, 1'b0, 8'h00);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 8'h00);
        check("R7 slot freed after five bits", not_full, 1'b1);
        for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 8'h00);

        // R8: empty shifter holds its output
        do_reset();
        req = "R8";
        while (cnt != 3'd0) step(1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b1, 8'h80);
        for (int k = 0; k < 24; k++) step(1'b1, 1'b0, 8'h00);
        check("R8 held high", sdo, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule